// File: doc/BRIEF.md
# Byte-Write Pipelined Synchronous SRAM

This block is a single-clock 32-bit synchronous memory with a parameterized number of words. On every rising clock edge it registers the address, the write data and all control inputs. A registered request that writes nothing is a read. The read word is captured into an output pipeline register on the following edge. All control inputs are active-low.

Writes use two levels of control. A global write stores all four bytes. Without it, each of four byte enables selects one byte lane, but only while the byte-write enable is low. The write finishes inside the clock cycle after the one that captured it, with no external write strobe.

The data output is gated by an output enable, and the gating does not wait for a clock edge. Three chip enables must all be asserted for an access to take place. A sleep input puts the array into power-down. When sleep is released, the block spends three wake-up cycles before it accepts accesses again. During sleep and wake-up, accesses are ignored and the outputs read as zero.

Top module: `bwsram`

## Requirements
- R1: Inputs are registered at a rising edge E0. A read request captured at E0 drives its word on `rdata_o`, with `rvalid_o` high, after the next edge E1. After E0 alone, `rvalid_o` is still low.
- R2: With `gw_n_i` high and `bwe_n_i` low, each low bit `be_n_i[n]` (n = 0..3) writes data bits [8n+7:8n] of `wdata_i`. Lanes whose enable is high keep their old content.
- R3: With `gw_n_i` low, all four bytes are written whatever the values of `bwe_n_i` and `be_n_i`.
- R4: With `gw_n_i` high and either `bwe_n_i` high or all of `be_n_i` high, the access is a read and the addressed word is unchanged.
- R5: An access (read or write) takes place only when all three bits of `ce_n_i` are low. Otherwise no word is written and no `rvalid_o` pulse follows.
- R6: While `oe_n_i` is high, `rdata_o` is zero and `rvalid_o` is low. The output changes without any clock edge.
- R7: Once an edge samples `sleep_i` high, the block is in power-down. Writes and reads issued while it is asleep are ignored, and `rdata_o` and `rvalid_o` stay zero.
- R8: After `sleep_i` returns low, there are three wake-up cycles. Commands sampled at the first four rising edges, counted from the first edge that sees `sleep_i` low, are ignored. The command at the fifth edge is executed.
- R9: A read issued in the cycle right after a write to the same address returns the newly written data.
- R10: After reset, `rvalid_o` is low and `rdata_o` is zero, and the block is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| sleep_i | input | 1 | Power-down request, active high |
| ce_n_i | input | 3 | Three chip enables, all must be low |
| addr_i | input | AW | Word address |
| wdata_i | input | 32 | Write data |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write qualifier, active low |
| be_n_i | input | 4 | Per-byte write enables, active low |
| oe_n_i | input | 1 | Output enable, active low |
| rdata_o | output | 32 | Read data (zero when gated) |
| rvalid_o | output | 1 | Read data valid |

## Verification
The assertions check several properties on every cycle:
- A deselected cycle never produces a request.
- An executed write changes exactly its masked lanes and leaves the other lanes of the word alone.
- An edge that samples sleep always enters power-down.
- The sequencer returns to the active state only after the full wake-up count.
- The outputs stay quiet while the block is not awake.

Some behaviours can only be shown by the bench's scenarios, because they involve what is read back later. These are:
- the exact read latency;
- the full set of 64 combinations of global write, byte-write enable and byte enables, checked against an arithmetic byte merge;
- the eight chip-enable patterns;
- the asynchronous output gating;
- which commands fall inside the wake-up window.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_SLEEP  = 2'd1,
        PM_WAKE   = 2'd2
    } pm_state_e;
endpackage

// File: rtl/bwsram_inreg.sv
module bwsram_inreg
    import bwsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic [2:0]    ce_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          gw_n_i,
    input  logic          bwe_n_i,
    input  logic [NB-1:0] be_n_i,
    output logic          req_valid_o,
    output logic [NB-1:0] req_mask_o,
    output logic [AW-1:0] req_addr_o,
    output logic [DW-1:0] req_data_o
);
    typedef struct packed {
        logic          valid;
        logic [NB-1:0] mask;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } in_s;

    in_s st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = accept_i && (ce_n_i == 3'b000);
        st_d.addr  = addr_i;
        st_d.data  = wdata_i;
        if (!gw_n_i) begin
            st_d.mask = {NB{1'b1}};
        end else if (!bwe_n_i) begin
            st_d.mask = ~be_n_i;
        end else begin
            st_d.mask = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid_o = st_q.valid;
    assign req_mask_o  = st_q.mask;
    assign req_addr_o  = st_q.addr;
    assign req_data_o  = st_q.data;

    // R5: a deselected cycle yields no request
    assert_deselect_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n_i != 3'b000) |=> !req_valid_o);
endmodule

// File: rtl/bwsram_power.sv
module bwsram_power
    import bwsram_pkg::*;
#(
    parameter int WAKE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    output logic active_o
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

    typedef struct packed {
        pm_state_e     state;
        logic [CW-1:0] cnt;
    } pm_s;

    pm_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sleep_i) begin
            st_d.state = PM_SLEEP;
            st_d.cnt   = '0;
        end else begin
            case (st_q.state)
                PM_SLEEP: begin
                    st_d.state = PM_WAKE;
                    st_d.cnt   = '0;
                end
                PM_WAKE: begin
                    if (st_q.cnt == LAST) begin
                        st_d.state = PM_ACTIVE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d.state = PM_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: PM_ACTIVE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.state == PM_ACTIVE);

    // R7: sampled sleep always enters power-down
    assert_sleep_enters_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (st_q.state == PM_SLEEP));

    // R8: wake-up only completes after the full count
    assert_wake_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == PM_ACTIVE && $past(st_q.state) == PM_WAKE) |-> ($past(st_q.cnt) == LAST));
endmodule

// File: rtl/bwsram_array.sv
module bwsram_array
    import bwsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_i,
    input  logic [NB-1:0] mask_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } out_s;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] bitmask;
    logic          wr_en;
    out_s          out_d, out_q;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign bitmask[b*8 +: 8] = {8{mask_i[b]}};
    end

    assign wr_en = exec_i && (mask_i != '0);

    always_comb begin
        out_d       = out_q;
        out_d.valid = exec_i && (mask_i == '0);
        if (out_d.valid) begin
            out_d.data = mem_q[addr_i];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[addr_i] <= (mem_q[addr_i] & ~bitmask) | (wdata_i & bitmask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rdata_o  = out_q.data;
    assign rvalid_o = out_q.valid;

    // R2: enabled lanes take the new data
    assert_lane_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem_q[$past(addr_i)] & $past(bitmask)) == ($past(wdata_i) & $past(bitmask))));

    // R2: disabled lanes keep their content
    assert_lane_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem_q[$past(addr_i)] & ~$past(bitmask)) == ($past(mem_q[addr_i]) & ~$past(bitmask))));
endmodule

// File: rtl/bwsram.sv
module bwsram
    import bwsram_pkg::*;
#(
    parameter int AW          = 6,
    parameter int WAKE_CYCLES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_i,
    input  logic [2:0]    ce_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic [31:0]   wdata_i,
    input  logic          gw_n_i,
    input  logic          bwe_n_i,
    input  logic [3:0]    be_n_i,
    input  logic          oe_n_i,
    output logic [31:0]   rdata_o,
    output logic          rvalid_o
);
    logic          active;
    logic          req_valid;
    logic [NB-1:0] req_mask;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic [DW-1:0] arr_data;
    logic          arr_valid;

    bwsram_power #(.WAKE_CYCLES(WAKE_CYCLES)) u_power (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_i  (sleep_i),
        .active_o (active)
    );

    bwsram_inreg #(.AW(AW)) u_inreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (active && !sleep_i),
        .ce_n_i      (ce_n_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .gw_n_i      (gw_n_i),
        .bwe_n_i     (bwe_n_i),
        .be_n_i      (be_n_i),
        .req_valid_o (req_valid),
        .req_mask_o  (req_mask),
        .req_addr_o  (req_addr),
        .req_data_o  (req_data)
    );

    bwsram_array #(.AW(AW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_i   (req_valid && active),
        .mask_i   (req_mask),
        .addr_i   (req_addr),
        .wdata_i  (req_data),
        .rdata_o  (arr_data),
        .rvalid_o (arr_valid)
    );

    assign rdata_o  = (!oe_n_i && active) ? arr_data : '0;
    assign rvalid_o = arr_valid && !oe_n_i && active;

    // R7: nothing leaves the block while it is not awake
    assert_quiet_asleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!rvalid_o && rdata_o == '0));

    // R6: disabled output never flags valid data
    assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> (!rvalid_o && rdata_o == '0));
endmodule

// File: tb/bwsram_tb.sv
`timescale 1ns/1ps
module bwsram_tb;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_i = 1'b0;
    logic [2:0]    ce_n_i = 3'b111;
    logic [AW-1:0] addr_i = '0;
    logic [31:0]   wdata_i = '0;
    logic          gw_n_i = 1'b1;
    logic          bwe_n_i = 1'b1;
    logic [3:0]    be_n_i = 4'hF;
    logic          oe_n_i = 1'b0;
    logic [31:0]   rdata_o;
    logic          rvalid_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [DEPTH];

    always #2.5 clk = ~clk;

    bwsram #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .ce_n_i(ce_n_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i),
        .be_n_i(be_n_i), .oe_n_i(oe_n_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_mask(input logic gw, input logic bwe, input logic [3:0] be);
        logic [3:0] m;
        m = !gw ? 4'hF : (!bwe ? ~be : 4'h0);
        return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    endfunction

    task automatic idle();
        ce_n_i = 3'b111; gw_n_i = 1'b1; bwe_n_i = 1'b1; be_n_i = 4'hF;
    endtask

    // drives one command for one cycle; model updated when accepted is expected
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic gw,
                      input logic bwe, input logic [3:0] be, input logic [2:0] ce, input logic take);
        logic [31:0] m;
        @(negedge clk);
        addr_i = a; wdata_i = d; gw_n_i = gw; bwe_n_i = bwe; be_n_i = be; ce_n_i = ce;
        @(negedge clk);
        idle();
        m = lane_mask(gw, bwe, be);
        if (take) model[a] = (model[a] & ~m) | (d & m);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [2:0] ce,
                      output logic [31:0] d, output logic v);
        @(negedge clk);
        addr_i = a; ce_n_i = ce; gw_n_i = 1'b1; bwe_n_i = 1'b1; be_n_i = 4'hF;
        @(negedge clk);
        idle();
        @(negedge clk);
        d = rdata_o; v = rvalid_o;
    endtask

    initial begin
        #1000000;
        failures++; checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 rvalid", {31'd0, rvalid_o}, 32'd0);
        chk("R10 rdata", rdata_o, 32'd0);

        // R3 + R1: fill every word with global write, read back
        for (int a = 0; a < DEPTH; a++)
            wr(AW'(a), 32'hA5000000 ^ (a * 32'h01030507), 1'b0, 1'b1, 4'hF, 3'b000, 1'b1);
        for (int a = 0; a < DEPTH; a++) begin
            rd(AW'(a), 3'b000, d, v);
            chk("R1 sweep data", d, model[a]);
            chk("R1 sweep valid", {31'd0, v}, 32'd1);
        end

        // R1: exact latency
        @(negedge clk);
        addr_i = 6'd3; ce_n_i = 3'b000;
        @(negedge clk);
        idle();
        chk("R1 not yet valid", {31'd0, rvalid_o}, 32'd0);
        @(negedge clk);
        chk("R1 valid after second edge", {31'd0, rvalid_o}, 32'd1);
        chk("R1 data after second edge", rdata_o, model[3]);

        // R2/R3/R4: all 64 write-control combinations
        for (int c = 0; c < 64; c++) begin
            wr(AW'(c), 32'h11223344 + c, 1'b0, 1'b1, 4'hF, 3'b000, 1'b1);
            wr(AW'(c), ~(32'h11223344 + c * 7), c[5], c[4], c[3:0], 3'b000, 1'b1);
            rd(AW'(c), 3'b000, d, v);
            chk("R2 R3 R4 lane merge", d, model[c]);
        end

        // R5: every chip-enable pattern
        for (int c = 0; c < 8; c++) begin
            wr(6'd40, 32'hC0DE0000 + c, 1'b0, 1'b1, 4'hF, 3'b000, 1'b1);
            wr(6'd40, 32'h0BAD0000 + c, 1'b0, 1'b1, 4'hF, 3'(c), c == 0);
            rd(6'd40, 3'b000, d, v);
            chk("R5 write gated by selects", d, model[40]);
            rd(6'd40, 3'(c), d, v);
            chk("R5 read valid only when selected", {31'd0, v}, {31'd0, c == 0});
        end

        // R6: output enable held high, then asynchronous toggle
        oe_n_i = 1'b1;
        rd(6'd7, 3'b000, d, v);
        chk("R6 rdata gated", d, 32'd0);
        chk("R6 rvalid gated", {31'd0, v}, 32'd0);
        oe_n_i = 1'b0;
        @(negedge clk);
        addr_i = 6'd7; ce_n_i = 3'b000;
        @(negedge clk);
        idle();
        @(negedge clk);
        chk("R6 visible before toggle", rdata_o, model[7]);
        oe_n_i = 1'b1;
        #1;
        chk("R6 async off data", rdata_o, 32'd0);
        chk("R6 async off valid", {31'd0, rvalid_o}, 32'd0);
        oe_n_i = 1'b0;
        #1;
        chk("R6 async on data", rdata_o, model[7]);

        // R9: read right behind write to same address
        @(negedge clk);
        addr_i = 6'd9; wdata_i = 32'hFEEDBEEF; gw_n_i = 1'b0; ce_n_i = 3'b000;
        @(negedge clk);
        gw_n_i = 1'b1;
        model[9] = 32'hFEEDBEEF;
        @(negedge clk);
        idle();
        @(negedge clk);
        chk("R9 read after write", rdata_o, 32'hFEEDBEEF);
        chk("R9 valid", {31'd0, rvalid_o}, 32'd1);

        // R7: sleep blocks accesses and quiets outputs
        @(negedge clk);
        sleep_i = 1'b1;
        @(negedge clk);
        chk("R7 asleep rvalid", {31'd0, rvalid_o}, 32'd0);
        chk("R7 asleep rdata", rdata_o, 32'd0);
        wr(6'd5, 32'hDEADDEAD, 1'b0, 1'b1, 4'hF, 3'b000, 1'b0);
        rd(6'd5, 3'b000, d, v);
        chk("R7 read ignored asleep", {31'd0, v}, 32'd0);

        // R8: release sleep, command every cycle to addresses 20..24
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            sleep_i = 1'b0;
            addr_i = AW'(20 + k); wdata_i = 32'h50000000 + k; gw_n_i = 1'b0; ce_n_i = 3'b000;
            if (k < 4) chk("R8 quiet while waking", {31'd0, rvalid_o}, 32'd0);
            if (k == 4) model[20 + k] = 32'h50000000 + k;
        end
        @(negedge clk);
        idle();
        for (int k = 0; k < 5; k++) begin
            rd(AW'(20 + k), 3'b000, d, v);
            chk("R8 wake window", d, model[20 + k]);
        end
        rd(6'd5, 3'b000, d, v);
        chk("R7 write during sleep ignored", d, model[5]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule